// File: doc/BRIEF.md
# Feedforward Network Sequencer

This block is the control unit for a small multilayer perceptron whose layers take their inputs one per clock cycle. Each neuron has one multiply-accumulate unit and its own weight ROM. Each layer has one shared activation lookup that reads whichever neuron output is currently selected. The sequencer turns one `start` request into a fixed train of strobes:

- a one-cycle bias load for every accumulator;
- a hidden-layer accumulate window, one cycle per network input;
- an output-layer accumulate window, one cycle per hidden neuron, while the hidden neurons are placed on the layer bus one at a time;
- a result phase that selects each output neuron in turn and ends with a one-cycle `done`.

A single address bus is driven for the whole network. Its lower codes index the input-pattern RAM and the hidden weight ROMs, and its upper codes index the output weight ROMs. Every ROM in the network can therefore hang off the same wires.

The activation lookup has a read latency of `ACT_LAT` cycles. The output-layer enable, and its address, trail the hidden-neuron select by that many cycles, so each product sees the activated value of the neuron selected earlier.

The layer sizes and the latency are parameters. With the default 3-5-1 network and one cycle of lookup latency, a pattern takes 12 cycles from the accepted `start` to `done`.

States and transitions:

- IDLE → LOAD on `start`.
- LOAD → HIDDEN after one cycle.
- HIDDEN → OUTPUT after `N_IN` cycles.
- OUTPUT → RESULT after `N_HID+ACT_LAT` cycles.
- RESULT → IDLE after `N_OUT+ACT_LAT` cycles.

`start` is only looked at in IDLE.

Top module: `ffn_sequencer`

## Requirements
- R1: During reset and whenever idle, `bias_load`, `hid_en`, `out_en` and `done` are 0, `hid_osel` and `out_osel` are all zero, and `addr` is 0. An asserted reset returns the block to idle at once, even mid-pattern.
- R2: When `start` is high at a clock edge while idle, `bias_load` is 1 for exactly the next cycle, with every other output at its idle value.
- R3: In the `N_IN` cycles after the load cycle, `hid_en` is 1 and `addr` counts 0, 1, …, `N_IN-1`.
- R4: In the `N_HID` cycles after the hidden window, `hid_osel` is one-hot, with bit 0 set first and then bit k set in the k-th of those cycles (bit i selects hidden neuron i).
- R5: `out_en` is 1 for `N_HID` cycles beginning `ACT_LAT` cycles after bit 0 of `hid_osel` is first set. In its k-th cycle, `addr` is `N_IN+k`. `out_en` never coincides with `bias_load` or `hid_en`.
- R6: After the output window, `out_osel` is one-hot for `N_OUT` cycles, stepping from bit 0 upward. `done` is 1 for one cycle, `ACT_LAT` cycles after the last output select. With the defaults this is the 12th cycle after the accepted `start`.
- R7: `start` has no effect from the load cycle through the `done` cycle inclusive.
- R8: A `start` held high across a pattern is accepted again in the first idle cycle after `done`, and the full strobe train repeats identically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to propagate one pattern |
| bias_load | output | 1 | Load bias into every accumulator |
| hid_en | output | 1 | Hidden-layer accumulate enable |
| out_en | output | 1 | Output-layer accumulate enable |
| hid_osel | output | N_HID | One-hot hidden-neuron output select |
| out_osel | output | N_OUT | One-hot output-neuron output select |
| addr | output | clog2(N_IN+N_HID) | Shared weight-ROM and input-RAM address |
| done | output | 1 | Activated network result valid |

## Verification
Each run is compared cycle by cycle against a strobe train computed from the layer sizes, so any slip of one phase boundary is seen. A clean run after reset checks the basic phase ordering. A run with `start` pulses in the load, hidden, output and `done` cycles separates a sequencer that ignores requests while busy from one that restarts. A run with `start` held high shows that the only re-acceptance point is the first idle cycle. A reset in the middle of the hidden window separates an asynchronous return to idle from one that finishes the pattern first.

// File: rtl/ffn_seq_pkg.sv
package ffn_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_HIDDEN,
        ST_OUTPUT,
        ST_RESULT
    } seq_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ffn_phase_counter.sv
module ffn_phase_counter #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else
            count <= count + CW'(1);
    end

endmodule

// File: rtl/ffn_onehot_sel.sv
module ffn_onehot_sel #(
    parameter int N  = 5,
    parameter int CW = 3
) (
    input  logic          en,
    input  logic [CW-1:0] idx,
    output logic [N-1:0]  sel
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign sel[i] = en && (int'(idx) == i);
    end

endmodule

// File: rtl/ffn_addr_gen.sv
module ffn_addr_gen #(
    parameter int N_IN    = 3,
    parameter int ACT_LAT = 1,
    parameter int CW      = 3,
    parameter int AW      = 3
) (
    input  logic          hid_en,
    input  logic          out_en,
    input  logic [CW-1:0] step,
    output logic [AW-1:0] addr
);

    // Lower codes: input RAM and hidden weights; upper codes: output weights.
    always_comb begin
        if (hid_en)
            addr = AW'(int'(step));
        else if (out_en)
            addr = AW'(N_IN + int'(step) - ACT_LAT);
        else
            addr = '0;
    end

endmodule

// File: rtl/ffn_sequencer.sv
module ffn_sequencer
    import ffn_seq_pkg::*;
#(
    parameter  int N_IN    = 3,
    parameter  int N_HID   = 5,
    parameter  int N_OUT   = 1,
    parameter  int ACT_LAT = 1,
    localparam int ADDR_W  = $clog2(N_IN + N_HID)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              bias_load,
    output logic              hid_en,
    output logic              out_en,
    output logic [N_HID-1:0]  hid_osel,
    output logic [N_OUT-1:0]  out_osel,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam int LEN_OUT = N_HID + ACT_LAT;
    localparam int LEN_RES = N_OUT + ACT_LAT;
    localparam int LEN_MAX = max3(N_IN, LEN_OUT, LEN_RES);
    localparam int CW      = $clog2(LEN_MAX + 1);

    seq_state_t    state, state_nx;
    logic [CW-1:0] cnt;
    int            phase_len;
    logic          phase_last;
    logic          hsel_en, osel_en;

    // Length of the current phase in cycles.
    always_comb begin
        unique case (state)
            ST_HIDDEN: phase_len = N_IN;
            ST_OUTPUT: phase_len = LEN_OUT;
            ST_RESULT: phase_len = LEN_RES;
            default:   phase_len = 1;
        endcase
    end

    assign phase_last = (int'(cnt) == phase_len - 1);

    ffn_phase_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (phase_last),
        .count (cnt)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)      state_nx = ST_LOAD;
            ST_LOAD:                   state_nx = ST_HIDDEN;
            ST_HIDDEN: if (phase_last) state_nx = ST_OUTPUT;
            ST_OUTPUT: if (phase_last) state_nx = ST_RESULT;
            ST_RESULT: if (phase_last) state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        bias_load = 1'b0;
        hid_en    = 1'b0;
        out_en    = 1'b0;
        hsel_en   = 1'b0;
        osel_en   = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_LOAD:   bias_load = 1'b1;
            ST_HIDDEN: hid_en    = 1'b1;
            ST_OUTPUT: begin
                hsel_en = (int'(cnt) < N_HID);
                out_en  = (int'(cnt) >= ACT_LAT);
            end
            ST_RESULT: begin
                osel_en = (int'(cnt) < N_OUT);
                done    = phase_last;
            end
            default: ;
        endcase
    end

    ffn_onehot_sel #(.N(N_HID), .CW(CW)) u_hsel (
        .en  (hsel_en),
        .idx (cnt),
        .sel (hid_osel)
    );

    ffn_onehot_sel #(.N(N_OUT), .CW(CW)) u_osel (
        .en  (osel_en),
        .idx (cnt),
        .sel (out_osel)
    );

    ffn_addr_gen #(.N_IN(N_IN), .ACT_LAT(ACT_LAT), .CW(CW), .AW(ADDR_W)) u_addr (
        .hid_en (hid_en),
        .out_en (out_en),
        .step   (cnt),
        .addr   (addr)
    );

endmodule

// File: rtl/ffn_sequencer_chk.sv
module ffn_sequencer_chk #(
    parameter int N_IN   = 3,
    parameter int N_HID  = 5,
    parameter int N_OUT  = 1,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bias_load,
    input logic              hid_en,
    input logic              out_en,
    input logic [N_HID-1:0]  hid_osel,
    input logic [N_OUT-1:0]  out_osel,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);

    // R2
    load_then_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bias_load |=> (hid_en && !bias_load));

    // R3
    hidden_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hid_en && $past(hid_en)) |-> (addr == $past(addr) + ADDR_W'(1)));

    // R3
    hidden_window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hid_en && addr == ADDR_W'(N_IN - 1)) |=> (!hid_en && hid_osel[0]));

    // R4
    hid_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hid_osel));

    // R4
    hid_sel_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hid_osel != '0 && !hid_osel[N_HID-1]) |=> (hid_osel == ($past(hid_osel) << 1)));

    // R5
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bias_load, hid_en, out_en}));

    // R6
    out_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_osel));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    no_load_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !bias_load);

endmodule

bind ffn_sequencer ffn_sequencer_chk #(
    .N_IN(N_IN), .N_HID(N_HID), .N_OUT(N_OUT), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bias_load(bias_load), .hid_en(hid_en),
    .out_en(out_en), .hid_osel(hid_osel), .out_osel(out_osel),
    .addr(addr), .done(done)
);

// File: tb/tb_ffn_sequencer.sv
module tb_ffn_sequencer;

    localparam int NI = 3;
    localparam int NH = 5;
    localparam int NO = 1;
    localparam int AL = 1;
    localparam int AW = $clog2(NI + NH);
    localparam int W  = 4 + NH + NO + AW;
    localparam int O0 = 2 + NI;          // first output-phase cycle
    localparam int R0 = O0 + NH + AL;    // first result-phase cycle
    localparam int L  = R0 + NO + AL - 1; // done cycle

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bias_load, hid_en, out_en, done;
    logic [NH-1:0] hid_osel;
    logic [NO-1:0] out_osel;
    logic [AW-1:0] addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ffn_sequencer #(.N_IN(NI), .N_HID(NH), .N_OUT(NO), .ACT_LAT(AL)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bias_load(bias_load),
        .hid_en(hid_en), .out_en(out_en), .hid_osel(hid_osel),
        .out_osel(out_osel), .addr(addr), .done(done)
    );

    // Expected outputs in cycle t after an accepted start (t<=0 or t>L: idle).
    function automatic logic [W-1:0] exp_vec(input int t);
        logic bl, he, oe, dn;
        logic [NH-1:0] hs;
        logic [NO-1:0] os;
        logic [AW-1:0] a;
        int c;
        bl = 0; he = 0; oe = 0; dn = 0; hs = '0; os = '0; a = '0;
        if (t == 1) bl = 1;
        else if (t >= 2 && t < O0) begin
            he = 1; a = AW'(t - 2);
        end else if (t >= O0 && t < R0) begin
            c = t - O0;
            if (c < NH) hs[c] = 1'b1;
            if (c >= AL) begin oe = 1; a = AW'(NI + c - AL); end
        end else if (t >= R0 && t <= L) begin
            c = t - R0;
            if (c < NO) os[c] = 1'b1;
            if (c == NO - 1 + AL) dn = 1;
        end
        return {bl, he, oe, dn, hs, os, a};
    endfunction

    function automatic string tag_of(input int t);
        if (t == 1) return "R2";
        if (t >= 2 && t < O0) return "R3";
        if (t >= O0 && t < O0 + AL) return "R4";
        if (t >= O0 + AL && t < R0) return "R5";
        if (t >= R0 && t <= L) return "R6";
        return "R1";
    endfunction

    task automatic check(input string req, input string lbl, input int t,
                         input logic [W-1:0] exp);
        logic [W-1:0] act;
        act = {bias_load, hid_en, out_en, done, hid_osel, out_osel, addr};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %b expected %b", req, lbl, t, act, exp);
        end
    endtask

    // R1: idle during and after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        start = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "in reset", 0, exp_vec(0));
        start = 1'b0;
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check("R1", "after reset", 0, exp_vec(0));
        end
    endtask

    // mode 0: clean; mode 1: start pokes while busy (R7); mode 2: start held (R8)
    task automatic t_run(input string lbl, input int mode);
        @(negedge clk);
        start = 1'b1;
        for (int t = 1; t <= L + 3; t++) begin
            @(negedge clk);
            if (mode == 2 && t > L + 1)
                check("R8", lbl, t, exp_vec(t - L - 1));
            else if (mode == 1)
                check((t <= L) ? "R7" : "R1", lbl, t, exp_vec(t));
            else
                check(tag_of(t), lbl, t, exp_vec(t));
            if (mode == 2) start = 1'b1;
            else if (mode == 1) start = (t == 1 || t == 3 || t == O0 + 1 || t == L);
            else start = 1'b0;
        end
        start = 1'b0;
        if (mode == 2) repeat (2 * L) @(negedge clk);
    endtask

    // R1: reset asserted in the middle of the hidden window.
    task automatic t_mid_reset();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R3", "before mid reset", 2, exp_vec(2));
        rst_n = 1'b0;
        #1;
        check("R1", "mid-run reset", 0, exp_vec(0));
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1", "after mid reset", 0, exp_vec(0));
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_run("clean", 0);
        t_run("busy start pokes", 1);
        t_run("held start", 2);
        t_mid_reset();
        t_run("clean after reset", 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule